// File: doc/BRIEF.md
# Mirrored Peripheral Bus Decoder

This block is the CPU-side front end of a video/sound peripheral on an 8-bit processor bus with a 13-bit address. It looks at each bus cycle and decides whether the peripheral is addressed. A write to the peripheral becomes a one-cycle strobe on one of the register lines, together with the registered write data. A read returns a byte in which only the two top bits come from the peripheral. The lower six bits show whatever last travelled on the data bus.

Because only a few address bits are decoded, every register appears at many addresses. Writes decode six index bits and reads decode four, so the write and read mirror sets are different. Write indices above the last defined register do nothing. Read indices above the last defined status source return zero in the two driven bits. The register contents behind the strobes are not part of this block. The status bits arrive as a flat input vector.

Top module: `mirror_bus_decoder`

## Requirements
- R1: `sel` is high exactly when address bit 12 and address bit 7 are both zero. No other address bit, including bit 9, affects it.
- R2: A qualifying write raises `wr_strobe[k]` for one cycle, in the clock cycle after the write, where k = address bits 5..0. In that same cycle `wr_data` holds the data bus value of the write.
- R3: A strobe is produced only when `sel`, `cpu_write` and `phi2_en` were all high in the previous cycle.
- R4: At most one bit of `wr_strobe` is high in any cycle.
- R5: A write to index 0x2D..0x3F produces no strobe and leaves `wr_data` unchanged.
- R6: The read source index is address bits 3..0. For index i below 14, `rd_data[7:6]` equals `status_bits[2i+1:2i]`.
- R7: For read index 14 or 15, `rd_data[7:6]` is zero.
- R8: `rd_data[5:0]` equals bits 5..0 of the data bus in the last cycle in which `bus_driven` was high. This is the high address byte of an absolute read when the bench drives it so.
- R9: `rd_oe` is high exactly when `sel` is high and `cpu_write` is low.
- R10: After synchronous reset, `wr_strobe` is zero, `wr_data` is zero and the held bus value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phi2_en | input | 1 | Phase-2 enable that qualifies write strobes |
| addr | input | 13 | CPU address |
| cpu_write | input | 1 | High for a write cycle, low for a read cycle |
| bus_driven | input | 1 | High when some agent drives the data bus this cycle |
| data_bus | input | 8 | Data bus value: CPU write data, memory data or an opcode byte |
| status_bits | input | 28 | Two status bits for each of 14 read sources |
| sel | output | 1 | Peripheral selected |
| rd_oe | output | 1 | Peripheral is the read target |
| wr_strobe | output | 45 | One-hot register write strobes |
| wr_data | output | 8 | Data of the last defined write |
| rd_data | output | 8 | Read byte: two status bits over six held bus bits |

## Verification
A write cycle both fires a strobe and reloads the bus-hold register, because the CPU drives the bus. The write sweep therefore checks, for each of the 8192 addresses, the strobe index, the suppression of undefined indices and the `wr_data` value. The read that follows then shows the held bits of that same write. The read sweep first puts a modelled high address byte on the bus, then reads with the bus released. The expected byte is computed from the status pattern and the held value. A final pass repeats selected writes with `phi2_en` low and expects silence.

// File: rtl/mbd_pkg.sv
// Package: shared sizes for the mirrored peripheral bus decoder.
// Assumes an 8-bit data bus and a 13-bit address bus.
package mbd_pkg;
    localparam int ADDR_W      = 13;
    localparam int DATA_W      = 8;
    localparam int WR_IDX_W    = 6;
    localparam int RD_IDX_W    = 4;
    localparam int NUM_WR_REGS = 45;   // indices 0x00..0x2C are defined
    localparam int NUM_RD_SRC  = 14;   // indices 0..13 are defined
    localparam int STAT_W      = 2;    // driven read bits per source
    localparam int HOLD_W      = DATA_W - STAT_W;
endpackage

// File: rtl/mbd_select.sv
// Module: address select. The peripheral answers when both select address
// bits are zero. Assumes the remaining address bits are don't-care.
module mbd_select (
    input  logic sel_hi_bit,
    input  logic sel_lo_bit,
    input  logic cpu_write,
    output logic sel,
    output logic rd_oe
);
    // Combine the two select bits and the direction.
    always_comb begin
        sel   = ~sel_hi_bit & ~sel_lo_bit;
        rd_oe = sel & ~cpu_write;
    end
endmodule

// File: rtl/mbd_wr_decode.sv
// Module: write decoder. It turns a qualified write into a registered one-hot
// strobe and captures the write data. Indices at or above NUM_REGS are ignored.
// Assumes `fire` is already qualified by select, write and phase-2 enable.
module mbd_wr_decode #(
    parameter int IDX_W    = 6,
    parameter int NUM_REGS = 45,
    parameter int DW       = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire,
    input  logic [IDX_W-1:0]    idx,
    input  logic [DW-1:0]       din,
    output logic [NUM_REGS-1:0] strobe,
    output logic [DW-1:0]       dout
);
    localparam int SPACE = 1 << IDX_W;

    logic [NUM_REGS-1:0] hit;
    logic                defined;

    // Compare the index against each defined register.
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_hit
        assign hit[k] = (idx == IDX_W'(k));
    end

    // The index is defined when it lies below the register count.
    always_comb defined = (int'(idx) < NUM_REGS) && (NUM_REGS <= SPACE);

    // Register the strobe pulse and the write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= '0;
            dout   <= '0;
        end else begin
            strobe <= fire ? hit : '0;
            if (fire && defined) dout <= din;
        end
    end

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe)); // R4
    AST_STROBE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> (strobe == '0)); // R3
    AST_UNDEF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && int'(idx) >= NUM_REGS) |=> (strobe == '0) && $stable(dout)); // R5
    AST_DATA_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(dout)); // R2
endmodule

// File: rtl/mbd_rd_path.sv
// Module: read path. It keeps the low bus bits in a bus-hold register and
// selects the two status bits for the read index. Undefined sources give zero.
// Assumes `bus_driven` flags every cycle in which an agent drives the bus.
module mbd_rd_path #(
    parameter int IDX_W   = 4,
    parameter int NUM_SRC = 14,
    parameter int SW      = 2,
    parameter int HW      = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_driven,
    input  logic [HW-1:0]       bus_lo,
    input  logic [IDX_W-1:0]    ridx,
    input  logic [NUM_SRC*SW-1:0] status,
    output logic [SW+HW-1:0]    rdata
);
    localparam int SLOTS = 1 << IDX_W;

    logic [SW-1:0] src [SLOTS];
    logic [HW-1:0] hold_q;

    // Map each read slot to its status pair, or to zero when undefined.
    for (genvar i = 0; i < SLOTS; i++) begin : g_src
        if (i < NUM_SRC) begin : g_def
            assign src[i] = status[i*SW +: SW];
        end else begin : g_undef
            assign src[i] = '0;
        end
    end

    // The bus-hold register follows the bus whenever it is driven.
    always_ff @(posedge clk) begin
        if (!rst_n)          hold_q <= '0;
        else if (bus_driven) hold_q <= bus_lo;
    end

    // Join the driven status bits with the held bus bits.
    always_comb rdata = {src[ridx], hold_q};

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_driven |=> $stable(rdata[HW-1:0])); // R8
    AST_HOLD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_driven |=> (rdata[HW-1:0] == $past(bus_lo))); // R8
endmodule

// File: rtl/mirror_bus_decoder.sv
// Module: top of the mirrored peripheral bus decoder. It performs the select,
// the six-bit write decode and the four-bit read decode with bus hold.
// Assumes one bus cycle per clock. Write strobes are qualified by phi2_en.
module mirror_bus_decoder
    import mbd_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         phi2_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         cpu_write,
    input  logic                         bus_driven,
    input  logic [DATA_W-1:0]            data_bus,
    input  logic [NUM_RD_SRC*STAT_W-1:0] status_bits,
    output logic                         sel,
    output logic                         rd_oe,
    output logic [NUM_WR_REGS-1:0]       wr_strobe,
    output logic [DATA_W-1:0]            wr_data,
    output logic [DATA_W-1:0]            rd_data
);
    logic wr_fire;
    logic unused_addr_bits;

    // Address bits that take no part in any decode.
    always_comb unused_addr_bits = ^{addr[11:8], addr[6]};

    mbd_select u_sel (
        .sel_hi_bit (addr[12]),
        .sel_lo_bit (addr[7]),
        .cpu_write  (cpu_write),
        .sel        (sel),
        .rd_oe      (rd_oe)
    );

    // Qualify the write with select, direction and phase-2 enable.
    always_comb wr_fire = sel & cpu_write & phi2_en;

    mbd_wr_decode #(
        .IDX_W    (WR_IDX_W),
        .NUM_REGS (NUM_WR_REGS),
        .DW       (DATA_W)
    ) u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (wr_fire),
        .idx    (addr[WR_IDX_W-1:0]),
        .din    (data_bus),
        .strobe (wr_strobe),
        .dout   (wr_data)
    );

    mbd_rd_path #(
        .IDX_W   (RD_IDX_W),
        .NUM_SRC (NUM_RD_SRC),
        .SW      (STAT_W),
        .HW      (HOLD_W)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_driven (bus_driven),
        .bus_lo     (data_bus[HOLD_W-1:0]),
        .ridx       (addr[RD_IDX_W-1:0]),
        .status     (status_bits),
        .rdata      (rd_data)
    );

    AST_NO_SEL_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[12] || addr[7]) |=> (wr_strobe == '0)); // R1
    AST_RD_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe && int'(addr[RD_IDX_W-1:0]) >= NUM_RD_SRC) |-> (rd_data[DATA_W-1 -: STAT_W] == '0)); // R7
    AST_OE_IMPLIES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> (sel && !cpu_write)); // R9
endmodule

// File: tb/mirror_bus_decoder_test.sv
module mirror_bus_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int NWR = 45;
    localparam int NRD = 14;
    localparam logic [27:0] STATUS = 28'hC6A_35B9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi2_en = 1'b0;
    logic [12:0] addr = '0;
    logic        cpu_write = 1'b0;
    logic        bus_driven = 1'b0;
    logic [7:0]  data_bus = '0;
    logic [27:0] status_bits = STATUS;
    logic        sel, rd_oe;
    logic [NWR-1:0] wr_strobe;
    logic [7:0]  wr_data, rd_data;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mirror_bus_decoder uut (
        .clk(clk), .rst_n(rst_n), .phi2_en(phi2_en), .addr(addr),
        .cpu_write(cpu_write), .bus_driven(bus_driven), .data_bus(data_bus),
        .status_bits(status_bits), .sel(sel), .rd_oe(rd_oe),
        .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
        end
    endtask

    function automatic logic exp_sel(input logic [12:0] a);
        return !a[12] && !a[7];
    endfunction

    function automatic logic [1:0] exp_stat(input logic [3:0] i);
        return (int'(i) < NRD) ? STATUS[2*i +: 2] : 2'b00;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] exp_wd;
        logic [5:0] exp_hold;
        exp_wd = '0;
        exp_hold = '0;
        repeat (3) @(negedge clk);
        // R10: reset state, read slot 15 with the bus released
        addr = 13'h000F;
        #1;
        check("R10 strobe", 64'(wr_strobe), 64'd0);
        check("R10 wr_data", 64'(wr_data), 64'd0);
        check("R10 hold", 64'(rd_data), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Write sweep over every address, phase-2 enabled
        for (int a = 0; a < 8192; a++) begin
            logic [12:0] ad;
            logic [7:0]  d;
            logic        fire;
            ad = 13'(a);
            d  = ad[7:0] ^ {ad[12:8], 3'b101};
            @(negedge clk);
            addr = ad; cpu_write = 1'b1; phi2_en = 1'b1;
            bus_driven = 1'b1; data_bus = d;
            #1;
            check("R1 sel", 64'(sel), 64'(exp_sel(ad)));
            check("R9 rd_oe write", 64'(rd_oe), 64'd0);
            fire = exp_sel(ad);
            @(posedge clk);
            #1;
            if (fire && int'(ad[5:0]) < NWR) begin
                exp_wd = d;
                check("R2 strobe", 64'(wr_strobe), 64'(NWR'(1) << ad[5:0]));
            end else if (fire) begin
                check("R5 undefined strobe", 64'(wr_strobe), 64'd0);
            end else begin
                check("R3 unselected strobe", 64'(wr_strobe), 64'd0);
            end
            check("R4 onehot", 64'($countones(wr_strobe) <= 1), 64'd1);
            check("R5 wr_data", 64'(wr_data), 64'(exp_wd));
            exp_hold = d[5:0];
        end

        // Read sweep: high address byte on the bus, then read with bus released
        for (int a = 0; a < 8192; a++) begin
            logic [12:0] ad;
            logic [7:0]  hb;
            ad = 13'(a);
            hb = {3'b000, ad[12:8]} ^ 8'h2A;
            @(negedge clk);
            cpu_write = 1'b0; phi2_en = 1'b1; bus_driven = 1'b1; data_bus = hb;
            addr = 13'h1FFF;
            @(negedge clk);
            exp_hold = hb[5:0];
            addr = ad; bus_driven = 1'b0; data_bus = 8'hFF;
            #1;
            check("R1 sel read", 64'(sel), 64'(exp_sel(ad)));
            check("R9 rd_oe", 64'(rd_oe), 64'(exp_sel(ad)));
            if (int'(ad[3:0]) < NRD)
                check("R6 status", 64'(rd_data[7:6]), 64'(exp_stat(ad[3:0])));
            else
                check("R7 undefined read", 64'(rd_data[7:6]), 64'd0);
            check("R8 held bits", 64'(rd_data[5:0]), 64'(exp_hold));
        end

        // R3: selected writes with phase-2 enable low must stay silent
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            addr = 13'(a) | 13'h0A00; cpu_write = 1'b1; phi2_en = 1'b0;
            bus_driven = 1'b1; data_bus = 8'h5A;
            @(posedge clk);
            #1;
            check("R3 phi2 low strobe", 64'(wr_strobe), 64'd0);
            check("R3 phi2 low wr_data", 64'(wr_data), 64'(exp_wd));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule